// File: doc/BRIEF.md
# Selectable Boolean Combining Element

This block is a stateless logic cell for a network of pattern-matching automata. It takes up to sixteen candidate signals from the surrounding network and a per-input select mask. It reduces the chosen inputs with one of nine Boolean functions, picked by a four-bit code. The result is a single output signal that other elements can consume. Inputs left out of the mask take the neutral value of the chosen function, so they never change the result.

An optional qualifier ties the output to an end-of-data strobe. With the qualifier enabled, a rule built on the element can only fire on the last symbol of a stream. The select mask, the function code and the qualifier enable are static configuration. The input signals and the end-of-data strobe change at the symbol rate. The output follows its inputs with no clock and no stored state.

Top module: `bool_combine_element`

## Requirements
- R1: An input whose `sel_mask` bit is 0 has no effect on `out_sig` for any function code.
- R2: Code 0 gives the AND of the selected inputs; code 2 gives its inverse (NAND).
- R3: Code 1 gives the OR of the selected inputs; codes 3 and 6 both give the inverse of that OR.
- R4: Code 4 gives the odd parity (XOR) of the selected inputs; code 5 gives its inverse (XNOR).
- R5: Code 7 gives a sum of products over input pairs (0,1), (2,3) … (14,15). Each pair with at least one selected member contributes the AND of its selected members. Pairs with no selected member contribute nothing.
- R6: Code 8 gives a product of sums over the same pairs. Each pair with at least one selected member contributes the OR of its selected members. Pairs with no selected member are ignored.
- R7: Codes 9 through 15 drive `out_sig` low whatever the other inputs are.
- R8: With `sel_mask` all zero, the output is the function of the empty set: 1 for codes 0, 3, 5, 6 and 8; 0 for codes 1, 2, 4 and 7.
- R9: When `eod_gate_en` is 1, `out_sig` equals the function result ANDed with `end_of_data`. When `eod_gate_en` is 0, `end_of_data` has no effect.
- R10: The element holds no state. `out_sig` depends only on the present input values, so the same inputs always give the same output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_sig | input | 16 | Candidate input signals from the network |
| sel_mask | input | 16 | 1 = the matching input takes part in the function |
| func_code | input | 4 | Function select, codes 0 to 8; 9 to 15 force the output low |
| eod_gate_en | input | 1 | 1 = qualify the result with end_of_data |
| end_of_data | input | 1 | Strobe that is high on the last symbol of a stream |
| out_sig | output | 1 | Combined result |

## Verification
The hardest cases to reach are the pairwise functions, codes 7 and 8, when only one member of a pair is selected. Here the identity value must be supplied inside the pair rather than across the whole reduction. The vector table drives masks such as a single low bit, or a single selected pair next to unselected ones. This shows that a half-selected pair reduces to its selected member and that an empty pair is ignored. The empty mask is also applied under every function code, with all inputs high, so that any leak of unselected inputs shows up in the output.

// File: rtl/boolc_pkg.sv
// Package: shared function codes for the Boolean combining element.
// Assumes a four-bit code field; values above FN_POS are reserved.
package boolc_pkg;
    localparam int FUNC_W = 4;

    typedef enum logic [FUNC_W-1:0] {
        FN_AND  = 4'd0,
        FN_OR   = 4'd1,
        FN_NAND = 4'd2,
        FN_NOR  = 4'd3,
        FN_XOR  = 4'd4,
        FN_XNOR = 4'd5,
        FN_NANY = 4'd6,
        FN_SOP  = 4'd7,
        FN_POS  = 4'd8
    } func_e;
endpackage

// File: rtl/bool_identity_fill.sv
// Module: replaces unselected inputs with the identity value of each
// reduction class. The AND view takes 1, the OR/XOR view takes 0.
// Assumes the mask and the input vector have the same width.
module bool_identity_fill #(
    parameter int NUM_IN = 16
) (
    input  logic [NUM_IN-1:0] in_vec,
    input  logic [NUM_IN-1:0] mask_vec,
    output logic [NUM_IN-1:0] and_view,
    output logic [NUM_IN-1:0] or_view
);
    // Fill in the neutral element wherever an input is not selected.
    always_comb begin
        and_view = in_vec | ~mask_vec;
        or_view  = in_vec &  mask_vec;
    end
endmodule

// File: rtl/bool_reduce_bank.sv
// Module: computes every reduction the element can select: the full AND,
// the full OR, the parity, and the pairwise sum-of-products and
// product-of-sums. Assumes NUM_IN is even; pairs are (2k, 2k+1).
module bool_reduce_bank #(
    parameter int NUM_IN = 16
) (
    input  logic [NUM_IN-1:0] and_view,
    input  logic [NUM_IN-1:0] or_view,
    input  logic [NUM_IN-1:0] mask_vec,
    output logic              all_and,
    output logic              any_or,
    output logic              parity,
    output logic              sop,
    output logic              pos
);
    localparam int PAIRS = NUM_IN / 2;

    logic [PAIRS-1:0] sop_term;
    logic [PAIRS-1:0] pos_term;

    // One product term and one sum term per input pair.
    for (genvar k = 0; k < PAIRS; k++) begin : g_pair
        logic pair_used;
        always_comb begin
            pair_used   = mask_vec[2*k] | mask_vec[2*k+1];
            sop_term[k] = pair_used & and_view[2*k] & and_view[2*k+1];
            pos_term[k] = ~pair_used | or_view[2*k] | or_view[2*k+1];
        end
    end

    // Wide reductions over the identity-filled views.
    always_comb begin
        all_and = &and_view;
        any_or  = |or_view;
        parity  = ^or_view;
        sop     = |sop_term;
        pos     = &pos_term;
    end
endmodule

// File: rtl/bool_func_mux.sv
// Module: picks the reduction named by the function code and applies the
// optional end-of-data qualifier. Reserved codes yield 0.
module bool_func_mux
    import boolc_pkg::*;
(
    input  logic [FUNC_W-1:0] func_code,
    input  logic              all_and,
    input  logic              any_or,
    input  logic              parity,
    input  logic              sop,
    input  logic              pos,
    input  logic              eod_gate_en,
    input  logic              end_of_data,
    output logic              out_sig
);
    logic raw;

    // Function selection by code.
    always_comb begin
        unique case (func_code)
            FN_AND:  raw = all_and;
            FN_OR:   raw = any_or;
            FN_NAND: raw = ~all_and;
            FN_NOR:  raw = ~any_or;
            FN_XOR:  raw = parity;
            FN_XNOR: raw = ~parity;
            FN_NANY: raw = ~any_or;
            FN_SOP:  raw = sop;
            FN_POS:  raw = pos;
            default: raw = 1'b0;
        endcase
    end

    // End-of-data qualification.
    always_comb out_sig = raw & (~eod_gate_en | end_of_data);
endmodule

// File: rtl/bool_combine_element.sv
// Module: top of the Boolean combining element. Masks the inputs, builds
// all reductions in parallel and selects one. Purely combinational.
// Assumes configuration inputs are held static while in use.
module bool_combine_element
    import boolc_pkg::*;
#(
    parameter int NUM_IN = 16
) (
    input  logic [NUM_IN-1:0] in_sig,
    input  logic [NUM_IN-1:0] sel_mask,
    input  logic [FUNC_W-1:0] func_code,
    input  logic              eod_gate_en,
    input  logic              end_of_data,
    output logic              out_sig
);
    logic [NUM_IN-1:0] and_view;
    logic [NUM_IN-1:0] or_view;
    logic all_and, any_or, parity, sop, pos;

    bool_identity_fill #(.NUM_IN(NUM_IN)) u_fill (
        .in_vec   (in_sig),
        .mask_vec (sel_mask),
        .and_view (and_view),
        .or_view  (or_view)
    );

    bool_reduce_bank #(.NUM_IN(NUM_IN)) u_reduce (
        .and_view (and_view),
        .or_view  (or_view),
        .mask_vec (sel_mask),
        .all_and  (all_and),
        .any_or   (any_or),
        .parity   (parity),
        .sop      (sop),
        .pos      (pos)
    );

    bool_func_mux u_mux (
        .func_code   (func_code),
        .all_and     (all_and),
        .any_or      (any_or),
        .parity      (parity),
        .sop         (sop),
        .pos         (pos),
        .eod_gate_en (eod_gate_en),
        .end_of_data (end_of_data),
        .out_sig     (out_sig)
    );
endmodule

// File: rtl/bool_combine_checker.sv
// Module: port-level checks for the combining element, attached by bind.
// The element has no clock, so the checks are immediate assertions on
// settled port values.
module bool_combine_checker
    import boolc_pkg::*;
#(
    parameter int NUM_IN = 16
) (
    input logic [NUM_IN-1:0] in_sig,
    input logic [NUM_IN-1:0] sel_mask,
    input logic [FUNC_W-1:0] func_code,
    input logic              eod_gate_en,
    input logic              end_of_data,
    input logic              out_sig
);
    // Port relations that must hold for every input combination.
    always_comb begin
        // R7
        reserved_code_low_chk: assert (!(func_code > 4'd8) || !out_sig);
        // R9
        eod_block_chk: assert (!(eod_gate_en && !end_of_data) || !out_sig);
        // R8
        empty_and_chk: assert (!(sel_mask == '0 && func_code == 4'd0 && !eod_gate_en) || out_sig);
        // R2
        and_full_chk: assert (!(func_code == 4'd0 && !eod_gate_en && (in_sig & sel_mask) == sel_mask) || out_sig);
        // R3
        or_hit_chk: assert (!(func_code == 4'd1 && !eod_gate_en && (in_sig & sel_mask) != '0) || out_sig);
    end
endmodule

bind bool_combine_element bool_combine_checker #(.NUM_IN(NUM_IN)) u_chk (
    .in_sig      (in_sig),
    .sel_mask    (sel_mask),
    .func_code   (func_code),
    .eod_gate_en (eod_gate_en),
    .end_of_data (end_of_data),
    .out_sig     (out_sig)
);

// File: tb/bool_combine_element_bench.sv
// Bench: table-driven check of the combining element, then directed
// tests for reserved codes, the empty mask and end-of-data gating.
module bool_combine_element_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] in_sig = '0;
    logic [15:0] sel_mask = '0;
    logic [3:0]  func_code = '0;
    logic        eod_gate_en = 1'b0;
    logic        end_of_data = 1'b0;
    logic        out_sig;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    bool_combine_element u_bool_combine_element (
        .in_sig      (in_sig),
        .sel_mask    (sel_mask),
        .func_code   (func_code),
        .eod_gate_en (eod_gate_en),
        .end_of_data (end_of_data),
        .out_sig     (out_sig)
    );

    // {func, mask, in, eod_en, eod, expected}
    localparam int NV = 22;
    localparam logic [38:0] VEC [NV] = '{
        {4'd0, 16'h00FF, 16'h00FF, 1'b0, 1'b0, 1'b1},  // R2 and all set
        {4'd0, 16'h00FF, 16'h00FE, 1'b0, 1'b0, 1'b0},  // R2 one clear
        {4'd0, 16'h00F0, 16'hFFF0, 1'b0, 1'b0, 1'b1},  // R1 unselected zeros
        {4'd1, 16'h0F00, 16'h00FF, 1'b0, 1'b0, 1'b0},  // R1 unselected ones
        {4'd1, 16'h0F00, 16'h0100, 1'b0, 1'b0, 1'b1},  // R3 or
        {4'd2, 16'h000F, 16'h000F, 1'b0, 1'b0, 1'b0},  // R2 nand
        {4'd2, 16'h000F, 16'h0007, 1'b0, 1'b0, 1'b1},  // R2 nand
        {4'd3, 16'hF000, 16'h0FFF, 1'b0, 1'b0, 1'b1},  // R3 nor
        {4'd3, 16'hF000, 16'h8000, 1'b0, 1'b0, 1'b0},  // R3 nor
        {4'd4, 16'hFFFF, 16'h0007, 1'b0, 1'b0, 1'b1},  // R4 xor odd
        {4'd4, 16'h00FF, 16'h0F03, 1'b0, 1'b0, 1'b0},  // R4 xor even
        {4'd5, 16'h00FF, 16'h0001, 1'b0, 1'b0, 1'b0},  // R4 xnor
        {4'd5, 16'h00FF, 16'hFF00, 1'b0, 1'b0, 1'b1},  // R4 xnor
        {4'd6, 16'h0003, 16'h0000, 1'b0, 1'b0, 1'b1},  // R3 inverted or
        {4'd6, 16'h0003, 16'h0002, 1'b0, 1'b0, 1'b0},  // R3 inverted or
        {4'd7, 16'h000F, 16'h0005, 1'b0, 1'b0, 1'b0},  // R5 no full pair
        {4'd7, 16'h000F, 16'h000C, 1'b0, 1'b0, 1'b1},  // R5 pair 1 full
        {4'd7, 16'h0001, 16'h0001, 1'b0, 1'b0, 1'b1},  // R5 half pair
        {4'd8, 16'h000F, 16'h0005, 1'b0, 1'b0, 1'b1},  // R6 each pair hit
        {4'd8, 16'h000F, 16'h0004, 1'b0, 1'b0, 1'b0},  // R6 pair 0 empty
        {4'd8, 16'h0030, 16'h0000, 1'b0, 1'b0, 1'b0},  // R6 one pair used
        {4'd1, 16'hFFFF, 16'h0001, 1'b1, 1'b1, 1'b1}   // R9 or at eod
    };

    // Empty-mask result per code 0..8.
    localparam logic [8:0] EMPTY_EXP = 9'b1_0110_1001;

    task automatic apply(input logic [3:0] f, input logic [15:0] m,
                         input logic [15:0] d, input logic en, input logic e);
        @(posedge clk);
        #2;
        func_code = f; sel_mask = m; in_sig = d;
        eod_gate_en = en; end_of_data = e;
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic exp);
        checks++;
        if (out_sig !== exp) begin
            errors++;
            $display("FAIL %s: func=%0d mask=%h in=%h en=%b eod=%b got=%b exp=%b",
                     req, func_code, sel_mask, in_sig, eod_gate_en,
                     end_of_data, out_sig, exp);
        end
    endtask

    initial begin
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        // R8: reset state, empty mask with code 0
        @(negedge clk);
        check("R8", 1'b1);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][38:35], VEC[i][34:19], VEC[i][18:3], VEC[i][2], VEC[i][1]);
            check("R1-table", VEC[i][0]);
        end

        // R8: empty mask under every code with all inputs high
        for (int f = 0; f < 9; f++) begin
            apply(4'(f), 16'h0000, 16'hFFFF, 1'b0, 1'b0);
            check("R8", EMPTY_EXP[f]);
        end

        // R7: reserved codes
        for (int f = 9; f < 16; f++) begin
            apply(4'(f), 16'hFFFF, 16'hFFFF, 1'b0, 1'b1);
            check("R7", 1'b0);
        end

        // R9: gating
        apply(4'd0, 16'h00FF, 16'h00FF, 1'b1, 1'b0);
        check("R9", 1'b0);
        apply(4'd0, 16'h00FF, 16'h00FF, 1'b1, 1'b1);
        check("R9", 1'b1);
        apply(4'd0, 16'h00FF, 16'h00FF, 1'b0, 1'b0);
        check("R9", 1'b1);
        apply(4'd0, 16'h0000, 16'h0000, 1'b1, 1'b0);
        check("R9", 1'b0);

        // R10: returning to an earlier input set gives the earlier result
        apply(4'd4, 16'hFFFF, 16'h0001, 1'b0, 1'b0);
        check("R10", 1'b1);
        apply(4'd4, 16'hFFFF, 16'h0003, 1'b0, 1'b0);
        check("R10", 1'b0);
        apply(4'd4, 16'hFFFF, 16'h0001, 1'b0, 1'b0);
        check("R10", 1'b1);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: got=timeout exp=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule